// File: doc/BRIEF.md
# Timing Violation Detector with Dual-Rail Report

This block models, at the level of a fast oversampling clock, the error detection logic that sits beside one stage of a resilient latch pipeline. The `phase` input is high while the stage latch is transparent. Each cycle of the fast clock is one tick. The block counts ticks from the rising edge of `phase`. It looks for any change on the N-bit data input inside a resiliency window. That window opens a compensation interval of `COMP` ticks after the phase edge and stays open for `WINDOW` ticks. A detected change is stretched into a pulse `PW` ticks wide. When that pulse overlaps the open window, a sticky violation flag is set. The flag is cleared whenever `phase` is low.

The flag is captured exactly once, on the first tick after the window closes. The captured verdict is returned on request through two rails that work as a return-to-zero handshake. A rising `sample_req` raises exactly one rail: `err_hi` for a violation, `err_lo` for a clean cycle. Lowering `sample_req` drops that rail again. A test input, `inject_tv`, acts as a synthetic data transition on the tick where it is high, so the detection path can be exercised without changing the data.

The window length is not set directly. It is derived from a nominal window, the pulse width and three path latencies, each given as its own parameter:

WINDOW = NOM_WIN + PW − FLAG_LAT − OR_LAT − SETUP_LAT

With the defaults, `COMP` = 3, `PW` = 2 and `WINDOW` = 8, so the flag is captured at tick 11. `COMP` is expected to be at least `PW`.

Top module: `tv_dualrail_det`

## Requirements
- R1: After reset both rails and `sample_ack` are 0, and the first request reports a clean cycle on `err_lo`.
- R2: A data change made while `phase` is low never produces a violation report. A cycle without a change reports clean even when the cycle before it was a violation.
- R3: Tick k is the k-th fast-clock edge with `phase` high, counting from 0. A change at tick t is ignored when t+PW−1 < COMP. With the defaults, ticks 0 and 1 are ignored and tick 2 is flagged.
- R4: A change at tick COMP, the first tick of the open window, is reported as a violation.
- R5: A change at tick COMP+WINDOW−1, the last open tick, is reported as a violation.
- R6: A change at tick COMP+WINDOW or later is not reported for that phase cycle.
- R7: A change on any single bit of `data_in` is detected. The lowest, a middle and the highest bit are each tested.
- R8: `inject_tv` high on a tick acts as a data change on that tick: flagged inside the window, ignored after it.
- R9: `err_hi` (violation) and `err_lo` (clean) are never high together. Exactly one of them rises on the clock edge after `sample_req` is first seen high, and it stays high while `sample_req` stays high. `sample_ack` is high exactly while a rail is high.
- R10: On the clock edge after `sample_req` is seen low, both rails are 0. While `sample_req` stays low, both rails stay 0.
- R11: The internal sticky flag is 0 on every cycle after one in which `phase` was low, and it rises only after a cycle with `phase` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one period is one tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase | input | 1 | High while the stage latch is transparent |
| data_in | input | DATA_W | Data observed for transitions |
| inject_tv | input | 1 | Synthetic transition on the tick where it is high |
| sample_req | input | 1 | Return-to-zero request for the verdict |
| err_hi | output | 1 | Violation rail |
| err_lo | output | 1 | Clean rail |
| sample_ack | output | 1 | High while either rail is high |

## Verification
The bound checker watches the handshake on every cycle. It checks that the rails are mutually exclusive, that a rail rises after a new request, that a raised rail holds while the request stays high, and that both rails drop after the request falls. It also checks that the sticky flag clears while `phase` is low and rises only during a high phase. Window placement can only be shown by the bench's directed phase cycles, because it depends on which tick a change falls on. Those cycles cover a change before the phase edge, changes in the compensation interval, changes at the first and last open ticks, a change just after the window closes, and injected transitions inside and outside the window.

// File: rtl/tvdr_pkg.sv
package tvdr_pkg;
  typedef enum logic [1:0] {
    RAIL_IDLE  = 2'b00,
    RAIL_CLEAN = 2'b01,
    RAIL_VIOL  = 2'b10
  } rail_e;
endpackage

// File: rtl/tvdr_edge.sv
module tvdr_edge #(
  parameter int DATA_W = 8,
  parameter int PW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              inject_tv,
  output logic              det_pulse
);
  localparam int SW = (PW > 1) ? $clog2(PW) + 1 : 1;
  localparam logic [SW-1:0] RELOAD = SW'(PW - 1);

  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] bit_chg;
  logic [SW-1:0]     str_q, str_d;
  logic              any_chg;

  // per-bit transition detectors (R7)
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bit_chg[b] = data_in[b] ^ prev_q[b];
  end

  // OR of every bit detector plus the synthetic transition (R8)
  assign any_chg   = (|bit_chg) | inject_tv;
  assign det_pulse = any_chg | (str_q != '0);

  always_comb begin
    if (any_chg)           str_d = RELOAD;
    else if (str_q != '0)  str_d = str_q - 1'b1;
    else                   str_d = str_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      str_q  <= '0;
    end else begin
      prev_q <= data_in;
      str_q  <= str_d;
    end
  end
endmodule

// File: rtl/tvdr_window.sv
module tvdr_window #(
  parameter int COMP   = 3,
  parameter int WINDOW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic det_pulse,
  output logic viol_flag,
  output logic verdict
);
  localparam int CNT_W = $clog2(COMP + WINDOW + 2);
  localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(COMP);
  localparam logic [CNT_W-1:0] CLOSE_AT = CNT_W'(COMP + WINDOW);

  logic [CNT_W-1:0] tick_q, tick_d;
  logic             flag_q, flag_d;
  logic             verd_q, verd_d;
  logic             win_open, cap_now, tick_en;

  // R3 R4 R5 R6: window spans ticks COMP .. COMP+WINDOW-1
  assign win_open = phase && (tick_q >= OPEN_AT) && (tick_q < CLOSE_AT);
  assign cap_now  = phase && (tick_q == CLOSE_AT);
  assign tick_en  = phase && (tick_q <= CLOSE_AT);

  always_comb begin
    if (!phase)       tick_d = '0;
    else if (tick_en) tick_d = tick_q + 1'b1;
    else              tick_d = tick_q;
  end

  // R2 R11: sticky flag forced low with phase low
  always_comb begin
    if (!phase) flag_d = 1'b0;
    else        flag_d = flag_q | (win_open & det_pulse);
  end

  always_comb begin
    verd_d = cap_now ? flag_q : verd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      flag_q <= 1'b0;
      verd_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      flag_q <= flag_d;
      verd_q <= verd_d;
    end
  end

  assign viol_flag = flag_q;
  assign verdict   = verd_q;
endmodule

// File: rtl/tvdr_handshake.sv
module tvdr_handshake
  import tvdr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_req,
  input  logic verdict,
  output logic err_hi,
  output logic err_lo
);
  rail_e rail_q, rail_d;
  logic  req_q;
  logic  req_new;

  assign req_new = sample_req & ~req_q;

  // R9 R10: return-to-zero dual-rail report
  always_comb begin
    rail_d = rail_q;
    if (!sample_req)
      rail_d = RAIL_IDLE;
    else if (req_new && rail_q == RAIL_IDLE)
      rail_d = verdict ? RAIL_VIOL : RAIL_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_q <= RAIL_IDLE;
      req_q  <= 1'b0;
    end else begin
      rail_q <= rail_d;
      req_q  <= sample_req;
    end
  end

  assign err_hi = (rail_q == RAIL_VIOL);
  assign err_lo = (rail_q == RAIL_CLEAN);
endmodule

// File: rtl/tv_dualrail_det.sv
module tv_dualrail_det #(
  parameter int DATA_W    = 8,
  parameter int NOM_WIN   = 8,
  parameter int PW        = 2,
  parameter int FLAG_LAT  = 1,
  parameter int OR_LAT    = 0,
  parameter int SETUP_LAT = 1,
  parameter int COMP      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase,
  input  logic [DATA_W-1:0] data_in,
  input  logic              inject_tv,
  input  logic              sample_req,
  output logic              err_hi,
  output logic              err_lo,
  output logic              sample_ack
);
  localparam int WINDOW = NOM_WIN + PW - FLAG_LAT - OR_LAT - SETUP_LAT;

  logic rst_meta, rst_ns;
  logic det_pulse, viol_flag, verdict;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  tvdr_edge #(.DATA_W(DATA_W), .PW(PW)) u_edge (
    .clk       (clk),
    .rst_n     (rst_ns),
    .data_in   (data_in),
    .inject_tv (inject_tv),
    .det_pulse (det_pulse)
  );

  tvdr_window #(.COMP(COMP), .WINDOW(WINDOW)) u_window (
    .clk       (clk),
    .rst_n     (rst_ns),
    .phase     (phase),
    .det_pulse (det_pulse),
    .viol_flag (viol_flag),
    .verdict   (verdict)
  );

  tvdr_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .sample_req (sample_req),
    .verdict    (verdict),
    .err_hi     (err_hi),
    .err_lo     (err_lo)
  );

  assign sample_ack = err_hi | err_lo;
endmodule

// File: rtl/tv_dualrail_det_chk.sv
module tv_dualrail_det_chk (
  input logic clk,
  input logic rst_ns,
  input logic phase,
  input logic sample_req,
  input logic err_hi,
  input logic err_lo,
  input logic sample_ack,
  input logic viol_flag
);
  // R9
  rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !(err_hi && err_lo));

  // R9
  rail_rise_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(sample_req) && !err_hi && !err_lo) |=> (err_hi || err_lo));

  // R9
  rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((err_hi || err_lo) && sample_req) |=> ($stable(err_hi) && $stable(err_lo)));

  // R9
  ack_match_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    sample_ack == (err_hi || err_lo));

  // R10
  rail_rtz_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !sample_req |=> (!err_hi && !err_lo));

  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !phase |=> !viol_flag);

  // R11
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(viol_flag) |-> $past(phase));
endmodule

bind tv_dualrail_det tv_dualrail_det_chk u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .phase      (phase),
  .sample_req (sample_req),
  .err_hi     (err_hi),
  .err_lo     (err_lo),
  .sample_ack (sample_ack),
  .viol_flag  (viol_flag)
);

// File: tb/test_tv_dualrail_det.sv
`timescale 1ns/1ps
module test_tv_dualrail_det;
  localparam int DW   = 8;
  localparam int COMP = 3;
  localparam int WIN  = 8;   // 8 + 2 - 1 - 0 - 1
  localparam int PWID = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic phase;
  logic [DW-1:0] data_in;
  logic inject_tv;
  logic sample_req;
  logic err_hi, err_lo, sample_ack;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tv_dualrail_det #(.DATA_W(DW)) i_tv_dualrail_det (
    .clk(clk), .rst_n(rst_n), .phase(phase), .data_in(data_in),
    .inject_tv(inject_tv), .sample_req(sample_req),
    .err_hi(err_hi), .err_lo(err_lo), .sample_ack(sample_ack)
  );

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: {hi,lo,ack} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one phase cycle; change at tick t (negative = before phase rises)
  task automatic phase_cycle(input int t, input int bitsel, input bit use_inj);
    for (int k = -3; k < 14; k++) begin
      @(negedge clk);
      phase     = (k >= 0);
      inject_tv = use_inj && (k == t);
      if (!use_inj && k == t) data_in[bitsel] = ~data_in[bitsel];
    end
    @(negedge clk);
    inject_tv = 1'b0;
    phase     = 1'b0;
  endtask

  // full return-to-zero handshake, checks the verdict rail
  task automatic ask(input bit exp_viol, input string req);
    @(negedge clk);
    sample_req = 1'b1;
    check3({err_hi, err_lo, sample_ack}, 3'b000, "R10 idle before request");
    @(negedge clk);
    check3({err_hi, err_lo, sample_ack}, exp_viol ? 3'b101 : 3'b011, req);
    @(negedge clk);
    check3({err_hi, err_lo, sample_ack}, exp_viol ? 3'b101 : 3'b011, "R9 rail held");
    sample_req = 1'b0;
    @(negedge clk);
    check3({err_hi, err_lo, sample_ack}, 3'b000, "R10 rail returns to zero");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; phase = 1'b0; data_in = '0; inject_tv = 1'b0; sample_req = 1'b0;
    repeat (3) @(negedge clk);
    check3({err_hi, err_lo, sample_ack}, 3'b000, "R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check3({err_hi, err_lo, sample_ack}, 3'b000, "R1 after release");
    ask(1'b0, "R1 first report clean");
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check3({err_hi, err_lo, sample_ack}, 3'b000, "R10 no request");
    end
  endtask

  initial begin
    t_reset();
    phase_cycle(-2, 0, 1'b0);          ask(1'b0, "R2 change before phase");
    phase_cycle(1, 3, 1'b0);           ask(1'b0, "R3 tick 1 masked");
    phase_cycle(COMP - PWID + 1, 0, 1'b0); ask(1'b1, "R3 tick 2 flagged");
    phase_cycle(COMP, 5, 1'b0);        ask(1'b1, "R4 first window tick");
    phase_cycle(COMP + WIN - 1, DW - 1, 1'b0); ask(1'b1, "R5 R7 last window tick");
    phase_cycle(COMP + WIN, 2, 1'b0);  ask(1'b0, "R6 tick after window");
    phase_cycle(6, 0, 1'b1);           ask(1'b1, "R8 inject in window");
    phase_cycle(COMP + WIN + 1, 0, 1'b1); ask(1'b0, "R8 inject after window");
    phase_cycle(99, 0, 1'b0);          ask(1'b0, "R2 quiet cycle clean");
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule